// File: doc/BRIEF.md
# Secure Debug Access Gate

This block decides, access by access, whether an external debugger, test controller or programmer may reach the device. Three non-volatile configuration bits together arm the protection: secure-debug enable, root-of-trust region enable and configuration-block write-protect. If any one of them is clear, the gate runs in pass-through mode and grants every request.

Once armed, the gate follows a two-bit access-control register that only root-of-trust firmware may normally write. Bit 0 is the unlock bit. It survives warm resets and clears only on a cold (power-on or brown-out) reset, so after every cold boot firmware must grant access again. Bit 1 is the debug-extension bit. It opens the root-of-trust flash region to external access, and while it is set any bus master may write the register.

With code protection on, reaching user program flash also needs a chip erase completed since the last cold reset. The gate also tells the JTAG logic to restrict itself to boundary scan while the device is locked. It exposes both register bits so that tools can read them, including in emulation mode.

Top module: `secdbg_gate`

## Requirements
- R1: Protection is active only when `cfg_secdbg`, `cfg_rot_en` and `cfg_wp` are all 1; otherwise every request with `req_valid`=1 is granted, whatever the register and request fields hold.
- R2: The access-control register holds the unlock bit at bit 0 and the debug-extension bit at bit 1 (`wr_data[0]`, `wr_data[1]`). `unlock_status` and `dbgx_status` show the written values from the clock edge that accepts the write.
- R3: A cold reset (`cold_rst_n`=0, asynchronous) clears both register bits and the erase flag. A warm reset (`warm_rst_n`=0, sampled at the clock edge) clears the debug-extension bit, leaves the unlock bit and the erase flag unchanged, and blocks register writes in that cycle.
- R4: A write (`wr_en`=1) is accepted only when `wr_from_rot`=1 or the debug-extension bit is already 1; any other write leaves both register bits unchanged.
- R5: While protection is active and the unlock bit is 0, every request is denied except boundary scan (`req_kind`=3) with `jtag_en`=1, and `jtag_bscan_only` is 1 exactly when `jtag_en`=1 in that state.
- R6: While protection is active and the unlock bit is 1, debug (`req_kind`=0), program (1) and test (2) requests are granted. Root-of-trust region requests (`req_region`=2) are granted only while the debug-extension bit is 1.
- R7: While protection is active and `cfg_cp`=1, a user program flash request (`req_region`=0) other than boundary scan is granted only when the unlock bit is 1 and a chip erase has completed since the last cold reset.
- R8: A one-cycle `erase_done` pulse sets the erase flag, which stays set until a cold reset. The erase does not change the grant decision for the root-of-trust (2) or one-time-programmable (3) regions.
- R9: `grant` depends combinationally on the request and the registered state in the same cycle, and it is 0 whenever `req_valid`=0.
- R10: In pass-through mode the register write and read rules of R2 to R4 still apply, so tools can read the unlock bit that firmware has set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| warm_rst_n | input | 1 | Warm reset, active low, synchronous |
| cfg_secdbg | input | 1 | Secure-debug enable configuration bit |
| cfg_rot_en | input | 1 | Root-of-trust region enable configuration bit |
| cfg_wp | input | 1 | Configuration-block write-protect bit |
| cfg_cp | input | 1 | Code-protect configuration bit |
| wr_en | input | 1 | Register write strobe |
| wr_from_rot | input | 1 | Write comes from root-of-trust firmware |
| wr_data | input | 2 | Write data: bit 0 unlock, bit 1 debug extension |
| erase_done | input | 1 | One-cycle chip-erase-complete pulse |
| jtag_en | input | 1 | JTAG port enabled |
| req_valid | input | 1 | External access request strobe |
| req_kind | input | 2 | 0 debug, 1 program, 2 test, 3 boundary scan |
| req_region | input | 2 | 0 user program, 1 user data, 2 root-of-trust, 3 OTP |
| grant | output | 1 | Access granted this cycle |
| jtag_bscan_only | output | 1 | JTAG limited to boundary scan |
| unlock_status | output | 1 | Unlock bit read-back |
| dbgx_status | output | 1 | Debug-extension bit read-back |

## Verification
The hardest state to reach is an unlocked, code-protected device whose unlock bit has survived a warm reset while the erase flag is still clear and the debug-extension bit has just been cleared. Reaching it takes an ordered sequence: a firmware write of both bits, then a warm reset, then user program flash and root-of-trust requests before the erase pulse arrives and again after it. The bench plays that sequence, sends a rejected non-firmware write once the extension bit has dropped, and ends with a cold reset to show that all of this state is lost.

// File: rtl/secdbg_gate.sv
module secdbg_gate (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       warm_rst_n,
  input  logic       cfg_secdbg,
  input  logic       cfg_rot_en,
  input  logic       cfg_wp,
  input  logic       cfg_cp,
  input  logic       wr_en,
  input  logic       wr_from_rot,
  input  logic [1:0] wr_data,
  input  logic       erase_done,
  input  logic       jtag_en,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic [1:0] req_region,
  output logic       grant,
  output logic       jtag_bscan_only,
  output logic       unlock_status,
  output logic       dbgx_status
);
  localparam logic [1:0] KIND_BSCAN = 2'd3;
  localparam logic [1:0] REG_UPF    = 2'd0;
  localparam logic [1:0] REG_ROT    = 2'd2;

  logic unlock_q, dbgx_q, erased_q;
  logic armed, wr_ok;

  assign armed = cfg_secdbg & cfg_rot_en & cfg_wp;
  assign wr_ok = wr_en & warm_rst_n & (wr_from_rot | dbgx_q);

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      unlock_q <= 1'b0;
      dbgx_q   <= 1'b0;
      erased_q <= 1'b0;
    end else begin
      if (!warm_rst_n) dbgx_q <= 1'b0;
      else if (wr_ok) begin
        unlock_q <= wr_data[0];
        dbgx_q   <= wr_data[1];
      end
      if (erase_done) erased_q <= 1'b1;
    end
  end

  always_comb begin
    grant = 1'b0;
    if (req_valid) begin
      if (!armed)                       grant = 1'b1;
      else if (req_kind == KIND_BSCAN)  grant = jtag_en;
      else if (!unlock_q)               grant = 1'b0;
      else if (req_region == REG_ROT)   grant = dbgx_q;
      else if (req_region == REG_UPF)   grant = !cfg_cp || erased_q;
      else                              grant = 1'b1;
    end
  end

  assign jtag_bscan_only = armed & ~unlock_q & jtag_en;
  assign unlock_status   = unlock_q;
  assign dbgx_status     = dbgx_q;

  p_passthru_r1: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!armed && req_valid) |-> grant);
  p_warm_keeps_unlock_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> (unlock_status == $past(unlock_status)) && !dbgx_status);
  p_foreign_wr_r4: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (wr_en && !wr_from_rot && !dbgx_status && warm_rst_n) |=> $stable({dbgx_status, unlock_status}));
  p_locked_deny_r5: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (armed && !unlock_status && req_kind != KIND_BSCAN) |-> !grant);
  p_rot_guard_r6: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (armed && !dbgx_status && req_region == REG_ROT && req_kind != KIND_BSCAN) |-> !grant);
  p_cp_erase_r7: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (armed && cfg_cp && !erased_q && req_region == REG_UPF && req_kind != KIND_BSCAN) |-> !grant);
  p_erase_sticky_r8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    erased_q |=> erased_q);
  p_idle_r9: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !req_valid |-> !grant);
endmodule

// File: tb/test_secdbg_gate.sv
module test_secdbg_gate;
  localparam int CLK_P = 10;

  logic clk = 0, cold_rst_n = 0, warm_rst_n = 1;
  logic cfg_secdbg = 1, cfg_rot_en = 1, cfg_wp = 1, cfg_cp = 0;
  logic wr_en = 0, wr_from_rot = 0, erase_done = 0, jtag_en = 0, req_valid = 0;
  logic [1:0] wr_data = 0, req_kind = 0, req_region = 0;
  logic grant, jtag_bscan_only, unlock_status, dbgx_status;

  int n_tests = 0, n_fail = 0;
  bit m_unlock = 0, m_dbgx = 0, m_erased = 0;

  always #(CLK_P/2) clk = ~clk;

  secdbg_gate i_secdbg_gate (.*);

  function automatic bit model_grant();
    bit on;
    on = cfg_secdbg && cfg_rot_en && cfg_wp;
    if (!req_valid) return 0;
    if (!on) return 1;
    if (req_kind == 3) return jtag_en;
    if (!m_unlock) return 0;
    if (req_region == 2) return m_dbgx;
    if (req_region == 0 && cfg_cp && !m_erased) return 0;
    return 1;
  endfunction

  task automatic check(input string tag);
    bit eg, eb;
    eg = model_grant();
    eb = cfg_secdbg && cfg_rot_en && cfg_wp && !m_unlock && jtag_en;
    n_tests++;
    if (grant !== eg || jtag_bscan_only !== eb || unlock_status !== m_unlock || dbgx_status !== m_dbgx) begin
      n_fail++;
      $display("FAIL %s: got g=%b b=%b u=%b x=%b exp g=%b b=%b u=%b x=%b", tag,
               grant, jtag_bscan_only, unlock_status, dbgx_status, eg, eb, m_unlock, m_dbgx);
    end
  endtask

  task automatic step(input string tag);
    #1 check(tag);
    @(posedge clk);
    if (!warm_rst_n) m_dbgx = 0;
    else if (wr_en && (wr_from_rot || m_dbgx)) {m_dbgx, m_unlock} = wr_data;
    if (erase_done) m_erased = 1;
    @(negedge clk);
    wr_en = 0; erase_done = 0; warm_rst_n = 1; req_valid = 0;
  endtask

  task automatic req(input logic [1:0] k, input logic [1:0] r, input string tag);
    req_valid = 1; req_kind = k; req_region = r;
    step(tag);
  endtask

  task automatic wr(input logic rot, input logic [1:0] d, input string tag);
    wr_en = 1; wr_from_rot = rot; wr_data = d;
    step(tag);
  endtask

  task automatic cold(input string tag);
    cold_rst_n = 0;
    #1 m_unlock = 0; m_dbgx = 0; m_erased = 0;
    check(tag);
    @(negedge clk) cold_rst_n = 1;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: got hung exp finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    cold("R3 reset");
    step("R9 idle");
    // locked
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 4; r++) req(k[1:0], r[1:0], "R5 locked");
    jtag_en = 1;
    req(3, 0, "R5 bscan");
    req(0, 1, "R5 jtag locked");
    // foreign write rejected
    wr(0, 2'b11, "R4 reject");
    req(0, 1, "R4 still locked");
    // firmware unlock only
    wr(1, 2'b01, "R2 unlock");
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 4; r++) req(k[1:0], r[1:0], "R6 unlocked");
    // code protect before erase
    cfg_cp = 1;
    req(0, 0, "R7 no erase");
    req(1, 0, "R7 no erase prog");
    req(0, 3, "R8 otp pre");
    // extension
    wr(1, 2'b11, "R2 dbgx");
    req(0, 2, "R6 rot open");
    wr(0, 2'b11, "R4 foreign ok");
    // warm reset
    warm_rst_n = 0; wr_en = 1; wr_from_rot = 1; wr_data = 2'b00;
    step("R3 warm");
    req(0, 0, "R3 unlock kept");
    req(0, 2, "R6 rot closed");
    wr(0, 2'b10, "R4 reject after warm");
    erase_done = 1;
    step("R8 erase pulse");
    req(0, 0, "R7 erased");
    req(1, 2, "R8 rot post");
    req(2, 3, "R8 otp post");
    // pass-through
    for (int c = 0; c < 7; c++) begin
      {cfg_secdbg, cfg_rot_en, cfg_wp} = c[2:0];
      req(0, 2, "R1 passthru");
      req(1, 0, "R1 passthru upf");
    end
    {cfg_secdbg, cfg_rot_en, cfg_wp} = 3'b111;
    cold("R3 cold clears");
    req(0, 0, "R8 erase lost");
    cfg_secdbg = 0;
    wr(1, 2'b01, "R10 emu write");
    req(0, 2, "R10 emu grant");
    wr(0, 2'b00, "R10 emu reject");
    req_valid = 0; step("R9 idle end");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule